// File: doc/BRIEF.md
# MMU Control and Fault Register Bank

This block is the register file that software uses to configure a paged memory management unit and to learn why a translation failed. A 3-bit register number, taken from address bits 10:8 of the access, selects one of five registers: the control word, the context table pointer, the current context number, the fault status word and the fault address. Configuration fields drive dedicated outputs to the translation logic, and the version and implementation fields read back as constants.

The translation logic reports each fault with a one-cycle strobe and a set of descriptive fields. The bank captures the fault type, the access kind, the walk level, the external bus error code and the virtual index bits of the failing access. If an earlier fault is still unread when a new one arrives, the bank keeps the newer fault and raises a sticky overwrite flag. Reading the fault status word returns its contents in the same cycle and clears it at the next clock edge. The fault address is left in place.

Top module: `mmu_regbank`

## Requirements
- R1: Register numbers decode as 000 control, 001 context table pointer, 010 context number, 011 fault status, 100 fault address. Numbers 101 to 111 read as zero, and writes to them change no register.
- R2: In the control word, bit 0 enable, bit 1 no-fault, bit 7 store ordering, bit 14 TLB separation, bit 15 TLB disable and bits 17:16 page size are writable. A written value appears on the matching outputs after the next clock edge. All other bits in 23:0 read as zero.
- R3: Control bits 31:28 read as the IMPL_CODE parameter and bits 27:24 as the VER_CODE parameter. Writes to them are ignored.
- R4: The context table pointer stores write-data bits 31:2. Bits 1:0 read as zero.
- R5: The context number register stores write-data bits 7:0. Higher bits read as zero.
- R6: A fault strobe loads the fault status as follows: bus error code in 17:10, level in 9:8, store=1 in bit 7, instruction=1 in bit 6, supervisor=1 in bit 5, fault type in 4:2, and 1 in bit 1 (address valid). It also loads the 20 fault-address bits into register 100, bits 19:0. Both take effect at the next edge.
- R7: A fault that arrives while status bit 1 is set, and with no status read in the same cycle, sets bit 0 (overwrite). The new fault's fields replace the old ones.
- R8: A read strobe on register 011 returns the current status combinationally and clears the whole status word at the next edge. If a fault arrives in that same cycle, the new fault is recorded with bit 0 = 0.
- R9: Software writes to the fault status and fault address registers are ignored. The fault address survives a status read.
- R10: After reset, every register and configuration output is zero, except the constant fields of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 3 | Register number (address bits 10:8) |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (triggers status clear) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regSel, combinational |
| faultValid | input | 1 | Fault report strobe |
| faultType | input | 3 | Fault type code |
| faultStore | input | 1 | 1 = store, 0 = load |
| faultInstr | input | 1 | 1 = instruction, 0 = data |
| faultSuper | input | 1 | 1 = supervisor, 0 = user |
| faultLevel | input | 2 | Walk level of the fault |
| faultBusErr | input | 8 | External bus error code |
| faultAddr | input | 20 | Virtual index bits of the faulting access |
| mmuEnable | output | 1 | Translation enable |
| noFault | output | 1 | Suppress fault traps |
| storeOrder | output | 1 | Partial store ordering |
| pageSize | output | 2 | Page size select |
| tlbDisable | output | 1 | TLB disabled |
| tlbSeparate | output | 1 | Separate instruction/data TLBs |
| ctxTablePtr | output | 30 | Context table pointer |
| ctxNum | output | 8 | Current context number |

## Verification
The properties assume that every input is a known value after reset. They also assume that the fault fields matter only in a cycle with faultValid set, and that a read strobe and a fault may coincide. The stimulus draws register numbers over all eight codes, including the unused ones. It issues reads, writes and fault strobes independently, so coincident read-and-fault and back-to-back faults occur often. It also runs directed sequences for the capture, overwrite and clear orderings.

// File: rtl/mmu_regbank_pkg.sv
package mmu_regbank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PTR_W  = DATA_W - 2;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_CTXPTR = 3'd1,
    SEL_CTXNUM = 3'd2,
    SEL_FSTAT  = 3'd3,
    SEL_FADDR  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic       wrCtrl;
    logic       wrPtr;
    logic       wrCtx;
    logic       statClear;
    logic [2:0] rdSel;
  } bankStrobes_t;
endpackage

// File: rtl/mmu_regbank_ctrl.sv
module mmu_regbank_ctrl
  import mmu_regbank_pkg::*;
(
  input  logic [2:0]   regSel,
  input  logic         wrEn,
  input  logic         rdEn,
  output bankStrobes_t strb
);
  always_comb begin
    strb.wrCtrl    = wrEn && (regSel == SEL_CTRL);
    strb.wrPtr     = wrEn && (regSel == SEL_CTXPTR);
    strb.wrCtx     = wrEn && (regSel == SEL_CTXNUM);
    strb.statClear = rdEn && (regSel == SEL_FSTAT);
    strb.rdSel     = regSel;
  end
endmodule

// File: rtl/mmu_regbank_dp.sv
module mmu_regbank_dp
  import mmu_regbank_pkg::*;
#(
  parameter int unsigned CTX_W     = 8,
  parameter int unsigned VIDX_W    = 20,
  parameter int unsigned EBE_W     = 8,
  parameter logic [3:0]  IMPL_CODE = 4'h3,
  parameter logic [3:0]  VER_CODE  = 4'h1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bankStrobes_t            strb,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    faultValid,
  input  logic [2:0]              faultType,
  input  logic                    faultStore,
  input  logic                    faultInstr,
  input  logic                    faultSuper,
  input  logic [1:0]              faultLevel,
  input  logic [EBE_W-1:0]        faultBusErr,
  input  logic [VIDX_W-1:0]       faultAddr,
  output logic [DATA_W-1:0]       rdData,
  output logic                    mmuEnable,
  output logic                    noFault,
  output logic                    storeOrder,
  output logic [1:0]              pageSize,
  output logic                    tlbDisable,
  output logic                    tlbSeparate,
  output logic [PTR_W-1:0]        ctxTablePtr,
  output logic [CTX_W-1:0]        ctxNum,
  output logic [EBE_W+9:0]        faultStatQ,
  output logic [VIDX_W-1:0]       faultAddrQ
);
  localparam int unsigned FS_W = EBE_W + 10;

  logic [FS_W-1:0] newStat;
  logic [DATA_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mmuEnable   <= 1'b0;
      noFault     <= 1'b0;
      storeOrder  <= 1'b0;
      pageSize    <= 2'b00;
      tlbDisable  <= 1'b0;
      tlbSeparate <= 1'b0;
    end else if (strb.wrCtrl) begin
      mmuEnable   <= wrData[0];
      noFault     <= wrData[1];
      storeOrder  <= wrData[7];
      tlbSeparate <= wrData[14];
      tlbDisable  <= wrData[15];
      pageSize    <= wrData[17:16];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctxTablePtr <= '0;
    end else if (strb.wrPtr) begin
      ctxTablePtr <= wrData[DATA_W-1:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctxNum <= '0;
    end else if (strb.wrCtx) begin
      ctxNum <= wrData[CTX_W-1:0];
    end
  end

  always_comb begin
    newStat = {faultBusErr, faultLevel, faultStore, faultInstr, faultSuper,
               faultType, 1'b1, faultStatQ[1] & ~strb.statClear};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultStatQ <= '0;
      faultAddrQ <= '0;
    end else if (faultValid) begin
      faultStatQ <= newStat;
      faultAddrQ <= faultAddr;
    end else if (strb.statClear) begin
      faultStatQ <= '0;
    end
  end

  always_comb begin
    ctrlWord = {IMPL_CODE, VER_CODE, 6'b0, pageSize, tlbDisable, tlbSeparate,
                6'b0, storeOrder, 5'b0, noFault, mmuEnable};
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CTRL:   rdData = ctrlWord;
      SEL_CTXPTR: rdData = {ctxTablePtr, 2'b00};
      SEL_CTXNUM: rdData = DATA_W'(ctxNum);
      SEL_FSTAT:  rdData = DATA_W'(faultStatQ);
      SEL_FADDR:  rdData = DATA_W'(faultAddrQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/mmu_regbank.sv
module mmu_regbank
  import mmu_regbank_pkg::*;
#(
  parameter int unsigned CTX_W     = 8,
  parameter int unsigned VIDX_W    = 20,
  parameter int unsigned EBE_W     = 8,
  parameter logic [3:0]  IMPL_CODE = 4'h3,
  parameter logic [3:0]  VER_CODE  = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              faultValid,
  input  logic [2:0]        faultType,
  input  logic              faultStore,
  input  logic              faultInstr,
  input  logic              faultSuper,
  input  logic [1:0]        faultLevel,
  input  logic [EBE_W-1:0]  faultBusErr,
  input  logic [VIDX_W-1:0] faultAddr,
  output logic              mmuEnable,
  output logic              noFault,
  output logic              storeOrder,
  output logic [1:0]        pageSize,
  output logic              tlbDisable,
  output logic              tlbSeparate,
  output logic [29:0]       ctxTablePtr,
  output logic [CTX_W-1:0]  ctxNum
);
  bankStrobes_t      strb;
  logic [EBE_W+9:0]  faultStatQ;
  logic [VIDX_W-1:0] faultAddrQ;

  mmu_regbank_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strb   (strb)
  );

  mmu_regbank_dp #(
    .CTX_W     (CTX_W),
    .VIDX_W    (VIDX_W),
    .EBE_W     (EBE_W),
    .IMPL_CODE (IMPL_CODE),
    .VER_CODE  (VER_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .faultValid  (faultValid),
    .faultType   (faultType),
    .faultStore  (faultStore),
    .faultInstr  (faultInstr),
    .faultSuper  (faultSuper),
    .faultLevel  (faultLevel),
    .faultBusErr (faultBusErr),
    .faultAddr   (faultAddr),
    .rdData      (rdData),
    .mmuEnable   (mmuEnable),
    .noFault     (noFault),
    .storeOrder  (storeOrder),
    .pageSize    (pageSize),
    .tlbDisable  (tlbDisable),
    .tlbSeparate (tlbSeparate),
    .ctxTablePtr (ctxTablePtr),
    .ctxNum      (ctxNum),
    .faultStatQ  (faultStatQ),
    .faultAddrQ  (faultAddrQ)
  );
endmodule

// File: rtl/mmu_regbank_chk.sv
module mmu_regbank_chk #(
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VIDX_W = 20,
  parameter int unsigned EBE_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [31:0]       wrData,
  input logic              faultValid,
  input logic [2:0]        faultType,
  input logic [VIDX_W-1:0] faultAddr,
  input logic [CTX_W-1:0]  ctxNum,
  input logic [EBE_W+9:0]  faultStatQ,
  input logic [VIDX_W-1:0] faultAddrQ
);
  // R6: a fault report is captured with the address-valid flag and its type
  p_fault_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> faultStatQ[1] && (faultStatQ[4:2] == $past(faultType))
                   && (faultAddrQ == $past(faultAddr)));

  // R7: a second unread fault raises the overwrite flag
  p_overwrite_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && faultStatQ[1] && !(rdEn && regSel == 3'd3) |=> faultStatQ[0]);

  // R8: a status read with no new fault empties the status word
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && regSel == 3'd3 && !faultValid |=> faultStatQ == '0);

  // R7: overwrite never stands without a valid fault
  p_ow_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultStatQ[0] |-> faultStatQ[1]);

  // R9: fault address only moves on a fault report
  p_faddr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |=> $stable(faultAddrQ));

  // R5: context number takes the low write-data bits
  p_ctx_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && regSel == 3'd2 |=> ctxNum == $past(wrData[CTX_W-1:0]));
endmodule

bind mmu_regbank mmu_regbank_chk #(
  .CTX_W  (CTX_W),
  .VIDX_W (VIDX_W),
  .EBE_W  (EBE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .wrData     (wrData),
  .faultValid (faultValid),
  .faultType  (faultType),
  .faultAddr  (faultAddr),
  .ctxNum     (ctxNum),
  .faultStatQ (faultStatQ),
  .faultAddrQ (faultAddrQ)
);

// File: tb/sim_mmu_regbank.sv
module sim_mmu_regbank;
  localparam logic [3:0] IMPL = 4'h3;
  localparam logic [3:0] VER  = 4'h1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [2:0]  regSel;
  logic        wrEn, rdEn;
  logic [31:0] wrData, rdData;
  logic        faultValid, faultStore, faultInstr, faultSuper;
  logic [2:0]  faultType;
  logic [1:0]  faultLevel;
  logic [7:0]  faultBusErr;
  logic [19:0] faultAddr;
  logic        mmuEnable, noFault, storeOrder, tlbDisable, tlbSeparate;
  logic [1:0]  pageSize;
  logic [29:0] ctxTablePtr;
  logic [7:0]  ctxNum;

  mmu_regbank #(.IMPL_CODE(IMPL), .VER_CODE(VER)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .faultValid(faultValid),
    .faultType(faultType), .faultStore(faultStore), .faultInstr(faultInstr),
    .faultSuper(faultSuper), .faultLevel(faultLevel), .faultBusErr(faultBusErr),
    .faultAddr(faultAddr), .mmuEnable(mmuEnable), .noFault(noFault),
    .storeOrder(storeOrder), .pageSize(pageSize), .tlbDisable(tlbDisable),
    .tlbSeparate(tlbSeparate), .ctxTablePtr(ctxTablePtr), .ctxNum(ctxNum)
  );

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] mCtrl, mPtr, mCtx, mFs, mFa;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] s);
    case (s)
      3'd0: return {IMPL, VER, mCtrl[23:0]};
      3'd1: return mPtr;
      3'd2: return mCtx;
      3'd3: return mFs;
      3'd4: return mFa;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R8";
      3'd4: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic compareAll();
    chk(tagOf(regSel), rdData, expRead(regSel));
    if (regSel == 3'd0) chk("R3", {24'h0, rdData[31:24]}, {24'h0, IMPL, VER});
    chk("R2", {24'h0, pageSize, tlbDisable, tlbSeparate, storeOrder, noFault, mmuEnable},
        {24'h0, mCtrl[17:16], mCtrl[15], mCtrl[14], mCtrl[7], mCtrl[1], mCtrl[0]});
    chk("R4", {ctxTablePtr, 2'b00}, mPtr);
    chk("R5", {24'h0, ctxNum}, mCtx);
  endtask

  task automatic modelEdge();
    logic clr;
    logic [31:0] fresh;
    clr = rdEn && regSel == 3'd3;
    if (wrEn) begin
      case (regSel)
        3'd0: mCtrl = wrData & 32'h0003_C083;
        3'd1: mPtr  = wrData & 32'hFFFF_FFFC;
        3'd2: mCtx  = wrData & 32'h0000_00FF;
        default: ;
      endcase
    end
    if (faultValid) begin
      fresh = 0;
      fresh[17:10] = faultBusErr;
      fresh[9:8]   = faultLevel;
      fresh[7]     = faultStore;
      fresh[6]     = faultInstr;
      fresh[5]     = faultSuper;
      fresh[4:2]   = faultType;
      fresh[1]     = 1'b1;
      fresh[0]     = mFs[1] && !clr;
      mFs = fresh;
      mFa = {12'h0, faultAddr};
    end else if (clr) begin
      mFs = 0;
    end
  endtask

  // one clock: inputs already set at negedge; compare, clock, update model
  task automatic step();
    #1;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic setBus(input logic [2:0] s, input logic w, input logic r, input logic [31:0] d);
    regSel = s; wrEn = w; rdEn = r; wrData = d;
  endtask

  task automatic setFault(input logic v, input logic [2:0] t, input logic st, input logic in,
                          input logic su, input logic [1:0] l, input logic [7:0] e,
                          input logic [19:0] a);
    faultValid = v; faultType = t; faultStore = st; faultInstr = in;
    faultSuper = su; faultLevel = l; faultBusErr = e; faultAddr = a;
  endtask

  task automatic peek(input logic [2:0] s);
    setBus(s, 1'b0, 1'b0, 32'h0);
    setFault(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 20'd0);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nVec++;
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    mCtrl = 0; mPtr = 0; mCtx = 0; mFs = 0; mFa = 0;
    rstN = 1'b0;
    setBus(3'd0, 1'b0, 1'b0, 32'h0);
    setFault(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, 20'd0);
    repeat (2) @(negedge clk);
    // R10: reset contents
    for (int s = 0; s < 8; s++) begin
      peek(3'(s));
      chk("R10", rdData, (s == 0) ? {IMPL, VER, 24'h0} : 32'h0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3: write all ones to control
    setBus(3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF); step();
    peek(3'd0); chk("R3", rdData, 32'h3103_C083);
    // R4
    setBus(3'd1, 1'b1, 1'b0, 32'hFFFF_FFFF); step();
    peek(3'd1); chk("R4", rdData, 32'hFFFF_FFFC);
    // R5
    setBus(3'd2, 1'b1, 1'b0, 32'h0000_1234); step();
    peek(3'd2); chk("R5", rdData, 32'h0000_0034);
    // R1: unused numbers
    for (int s = 5; s < 8; s++) begin
      setBus(3'(s), 1'b1, 1'b0, 32'h0); step();
    end
    peek(3'd0); chk("R1", rdData, 32'h3103_C083);
    peek(3'd6); chk("R1", rdData, 32'h0);
    // R6: first fault
    setBus(3'd0, 1'b0, 1'b0, 32'h0);
    setFault(1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 2'd3, 8'hA5, 20'hABCDE); step();
    peek(3'd3); chk("R6", rdData, 32'h0002_97AA);
    peek(3'd4); chk("R6", rdData, 32'h000A_BCDE);
    // R9: software writes to fault registers ignored
    setBus(3'd3, 1'b1, 1'b0, 32'h0); step();
    setBus(3'd4, 1'b1, 1'b0, 32'h0); step();
    peek(3'd3); chk("R9", rdData, 32'h0002_97AA);
    // R7: second unread fault
    setBus(3'd0, 1'b0, 1'b0, 32'h0);
    setFault(1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 2'd1, 8'h00, 20'h12345); step();
    peek(3'd3); chk("R7", rdData, 32'h0000_0147);
    // R8: read clears, address kept
    setBus(3'd3, 1'b0, 1'b1, 32'h0); step();
    peek(3'd3); chk("R8", rdData, 32'h0);
    peek(3'd4); chk("R9", rdData, 32'h0001_2345);
    // R8: fault in the same cycle as a read after a valid fault
    setFault(1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 8'h01, 20'h00001); step();
    setBus(3'd3, 1'b0, 1'b1, 32'h0);
    setFault(1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 2'd2, 8'hFF, 20'hFFFFF); step();
    peek(3'd3); chk("R8", rdData, 32'h0003_FEFA);

    // mixed traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      setBus(3'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 2) == 0), $urandom);
      setFault(($urandom_range(0, 3) == 0), 3'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 2'($urandom), 8'($urandom), 20'($urandom));
      step();
    end
    finishRun();
  end
endmodule